// File: doc/BRIEF.md
# Nested Trap Entry and Return Sequencer

This block sequences entry into and return from nested traps for a processor with register windows. When a trap is requested with a 9-bit trap type, it saves the machine context on a per-level stack slot chosen by the current trap level. The saved context is the condition codes, address-space identifier, masked processor state, window pointer, PC, next-PC and trap type. It then produces the new processor state, window pointer, trap base and trap level. It also produces the handler PC and next-PC.

Two return operations unwind one level. A "done" return resumes after the trapping instruction. A "retry" return re-executes it. Both restore the saved context. The block does not hold the register file and does not fetch instructions. It takes the live control values as inputs and, one cycle after a request, presents the updated control values with a valid strobe. A request it cannot honour sets an error strobe instead and changes nothing.

Top module: `trap_seq_top`

## Requirements
- R1: After a synchronous active-low reset, the trap level is 0 and the low 15 bits of the trap base are 0. Both the valid strobe and the error strobe are low. The current trap type output reads 0.
- R2: A retry return gives back, unchanged, the condition codes, ASI and window pointer saved at entry. It also gives back the processor state saved at entry ANDed with 0xF3F. The context is kept in a 40-bit word: codes at [39:32], ASI at [31:24], state at [19:8], window at [7:0].
- R3: On a successful entry the processor state becomes 0x015 (alternate globals bit 0, privileged bit 2, FP enable bit 4). Bit 5 (red state) is added when the entry starts at a trap level of MAXTL-1 or more.
- R4: On entry the window pointer is adjusted modulo NWIN. Type 0x024 subtracts 1. Types whose bits [8:6] are 010 subtract the can-save count plus 2. Types whose bits [8:6] are 011 add 1. Any other type leaves the pointer unchanged.
- R5: On entry the low 15 bits of the trap base become: bit 14 set when the trap level before entry exceeds 1, bits [13:5] equal to the trap type, and bits [4:0] zero. The upper bits come from the base input.
- R6: One cycle after a successful entry the valid strobe is high, the PC equals the full trap base value, and the next-PC equals PC+4. The condition codes and ASI outputs carry the live inputs.
- R7: A successful entry raises the trap level by one. An entry at trap level MAXTL raises the error strobe and saves nothing. In that case the valid strobe stays low and the trap level is unchanged.
- R8: A done return lowers the trap level by one. It sets PC to the next-PC saved at that level and next-PC to that value plus 4.
- R9: A retry return lowers the trap level by one. It sets PC to the saved PC and next-PC to the saved next-PC.
- R10: A done or retry return at trap level 0 raises the error strobe and changes no output.
- R11: When several requests arrive in the same cycle, trap entry wins over done, and done wins over retry.
- R12: The current trap type output shows the type saved at level TL-1, or 0 when TL is 0.
- R13: Nested entries and returns behave as a last-in first-out stack, so each return restores the context of the matching entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Request trap entry |
| trap_type | input | 9 | Type of the requested trap |
| done_req | input | 1 | Request a done return |
| retry_req | input | 1 | Request a retry return |
| ccr_i | input | 8 | Live condition codes |
| asi_i | input | 8 | Live address-space identifier |
| pstate_i | input | 12 | Live processor state |
| cwp_i | input | CWP_W | Live window pointer |
| cansave_i | input | CWP_W | Live can-save window count |
| pc_i | input | ADDR_W | Live PC |
| npc_i | input | ADDR_W | Live next-PC |
| tba_base_i | input | ADDR_W-15 | Upper bits of the trap base |
| upd_valid_o | output | 1 | Updated control values are valid this cycle |
| err_o | output | 1 | Request refused (stack full or empty) |
| pc_o | output | ADDR_W | New PC |
| npc_o | output | ADDR_W | New next-PC |
| ccr_o | output | 8 | New condition codes |
| asi_o | output | 8 | New ASI |
| pstate_o | output | 12 | New processor state |
| cwp_o | output | CWP_W | New window pointer |
| tl_o | output | TL_W | Current trap level |
| tbr_o | output | ADDR_W | Trap base value |
| cur_tt_o | output | 9 | Trap type of the innermost outstanding trap |

## Verification
The bench drives traps down to the maximum level and one past it. A design that checks the limit at the wrong level would either overwrite a stack slot or refuse a legal entry. It takes a spill trap with a large can-save count from a low window pointer and a fill trap from the top window; these catch window arithmetic that does not wrap modulo the window count. It enters with a processor state of all ones, which exposes a missing 0xF3F mask on restore. It also sends coincident trap, done and retry requests and a return at level zero. These catch a reversed priority and an underflow that would read a stale slot.

// File: rtl/trap_seq_pkg.sv
// Shared constants and the saved-context layout for the trap sequencer.
// Assumes a 12-bit processor state and a 9-bit trap type.
package trap_seq_pkg;
    localparam int TT_W        = 9;
    localparam int PS_W        = 12;
    localparam int PS_AG       = 0;
    localparam int PS_PRIV     = 2;
    localparam int PS_PEF      = 4;
    localparam int PS_RED      = 5;
    localparam logic [PS_W-1:0] PS_KEEP   = 12'hF3F;
    localparam logic [TT_W-1:0] TT_CLEAN  = 9'h024;
    localparam logic [2:0]      CLS_SPILL = 3'b010;
    localparam logic [2:0]      CLS_FILL  = 3'b011;
    localparam int TBR_LO_W    = 15;

    // 40-bit saved context; field positions are fixed by the return path
    typedef struct packed {
        logic [7:0]      ccr;
        logic [7:0]      asi;
        logic [3:0]      rsvd;
        logic [PS_W-1:0] ps;
        logic [7:0]      win;
    } ctx_word_t;
endpackage

// File: rtl/trap_entry_calc.sv
// Combinational entry arithmetic: new window pointer, processor state and
// low trap-base bits from the trap type and the level before entry.
// Assumes NWIN is a power of two so CWP_W-bit wrap equals modulo NWIN.
module trap_entry_calc
    import trap_seq_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int MAXTL = 5,
    parameter int CWP_W = $clog2(NWIN),
    parameter int TL_W  = $clog2(MAXTL + 1)
) (
    input  logic [TT_W-1:0]     tt,
    input  logic [CWP_W-1:0]    cwp,
    input  logic [CWP_W-1:0]    cansave,
    input  logic [TL_W-1:0]     tl,
    output logic [CWP_W-1:0]    cwp_n,
    output logic [PS_W-1:0]     ps_n,
    output logic [TBR_LO_W-1:0] tbr_lo_n
);
    localparam logic [TL_W-1:0] TL_RED = TL_W'(MAXTL - 1);

    logic red;

    // Window adjustment chosen by trap class
    always_comb begin
        if (tt == TT_CLEAN)
            cwp_n = cwp - CWP_W'(1);
        else if (tt[8:6] == CLS_SPILL)
            cwp_n = cwp - cansave - CWP_W'(2);
        else if (tt[8:6] == CLS_FILL)
            cwp_n = cwp + CWP_W'(1);
        else
            cwp_n = cwp;
    end

    // Handler processor state, red bit when entering near the top level
    always_comb begin
        red             = (tl >= TL_RED);
        ps_n            = '0;
        ps_n[PS_AG]     = 1'b1;
        ps_n[PS_PRIV]   = 1'b1;
        ps_n[PS_PEF]    = 1'b1;
        ps_n[PS_RED]    = red;
    end

    // Vector offset: nested flag, type, zero low bits
    always_comb begin
        tbr_lo_n = {(tl > TL_W'(1)), tt, 5'b00000};
    end
endmodule

// File: rtl/trap_stack.sv
// Per-level storage of saved context, PC, next-PC and trap type.
// One write port and one combinational read port; index beyond DEPTH reads 0.
module trap_stack
    import trap_seq_pkg::*;
#(
    parameter int DEPTH  = 5,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  ctx_word_t         wr_word,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic [ADDR_W-1:0] wr_npc,
    input  logic [TT_W-1:0]   wr_tt,
    input  logic [IDX_W-1:0]  rd_idx,
    output ctx_word_t         rd_word,
    output logic [ADDR_W-1:0] rd_pc,
    output logic [ADDR_W-1:0] rd_npc,
    output logic [TT_W-1:0]   rd_tt
);
    ctx_word_t         word_a [DEPTH];
    logic [ADDR_W-1:0] pc_a   [DEPTH];
    logic [ADDR_W-1:0] npc_a  [DEPTH];
    logic [TT_W-1:0]   tt_a   [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
        ctx_word_t         word_q;
        logic [ADDR_W-1:0] pc_q;
        logic [ADDR_W-1:0] npc_q;
        logic [TT_W-1:0]   tt_q;

        // Capture the level's slot when it is the write target
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
                pc_q   <= '0;
                npc_q  <= '0;
                tt_q   <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                word_q <= wr_word;
                pc_q   <= wr_pc;
                npc_q  <= wr_npc;
                tt_q   <= wr_tt;
            end
        end

        assign word_a[g] = word_q;
        assign pc_a[g]   = pc_q;
        assign npc_a[g]  = npc_q;
        assign tt_a[g]   = tt_q;
    end

    // Read mux with out-of-range guard
    always_comb begin
        rd_word = '0;
        rd_pc   = '0;
        rd_npc  = '0;
        rd_tt   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_word = word_a[i];
                rd_pc   = pc_a[i];
                rd_npc  = npc_a[i];
                rd_tt   = tt_a[i];
            end
        end
    end

    // R7: a write never targets a slot past the stack depth
    a_r7_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(DEPTH)));
endmodule

// File: rtl/trap_seq_top.sv
// Nested trap entry/return sequencer. Owns the trap level, the low trap-base
// bits and the per-level stack; takes live control values as inputs and
// registers the updated values one cycle after a request.
// Assumes at most one honoured request per cycle (trap > done > retry).
module trap_seq_top
    import trap_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MAXTL  = 5,
    parameter int NWIN   = 8,
    parameter int CWP_W  = $clog2(NWIN),
    parameter int TL_W   = $clog2(MAXTL + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trap_req,
    input  logic [TT_W-1:0]      trap_type,
    input  logic                 done_req,
    input  logic                 retry_req,
    input  logic [7:0]           ccr_i,
    input  logic [7:0]           asi_i,
    input  logic [PS_W-1:0]      pstate_i,
    input  logic [CWP_W-1:0]     cwp_i,
    input  logic [CWP_W-1:0]     cansave_i,
    input  logic [ADDR_W-1:0]    pc_i,
    input  logic [ADDR_W-1:0]    npc_i,
    input  logic [ADDR_W-16:0]   tba_base_i,
    output logic                 upd_valid_o,
    output logic                 err_o,
    output logic [ADDR_W-1:0]    pc_o,
    output logic [ADDR_W-1:0]    npc_o,
    output logic [7:0]           ccr_o,
    output logic [7:0]           asi_o,
    output logic [PS_W-1:0]      pstate_o,
    output logic [CWP_W-1:0]     cwp_o,
    output logic [TL_W-1:0]      tl_o,
    output logic [ADDR_W-1:0]    tbr_o,
    output logic [TT_W-1:0]      cur_tt_o
);
    localparam logic [TL_W-1:0] TL_TOP = TL_W'(MAXTL);

    logic [TL_W-1:0]     tl_q;
    logic [TBR_LO_W-1:0] tbr_lo_q;
    logic                do_ret, is_done, trap_ok, ret_ok;
    logic [TL_W-1:0]     rd_idx;
    logic [CWP_W-1:0]    cwp_n;
    logic [PS_W-1:0]     ps_n;
    logic [TBR_LO_W-1:0] tbr_lo_n;
    logic [ADDR_W-1:0]   vec_pc;
    ctx_word_t           save_word, rd_word;
    logic [ADDR_W-1:0]   rd_pc, rd_npc;
    logic [TT_W-1:0]     rd_tt;

    // Request arbitration and legality
    always_comb begin
        do_ret  = !trap_req && (done_req || retry_req);
        is_done = done_req;
        trap_ok = trap_req && (tl_q != TL_TOP);
        ret_ok  = do_ret && (tl_q != '0);
        rd_idx  = (tl_q != '0) ? (tl_q - TL_W'(1)) : '0;
        vec_pc  = {tba_base_i, tbr_lo_n};
    end

    // Pack the live context into the saved word
    always_comb begin
        save_word      = '0;
        save_word.ccr  = ccr_i;
        save_word.asi  = asi_i;
        save_word.ps   = pstate_i & PS_KEEP;
        save_word.win  = 8'(cwp_i);
    end

    trap_entry_calc #(
        .NWIN(NWIN), .MAXTL(MAXTL), .CWP_W(CWP_W), .TL_W(TL_W)
    ) u_calc (
        .tt(trap_type), .cwp(cwp_i), .cansave(cansave_i), .tl(tl_q),
        .cwp_n(cwp_n), .ps_n(ps_n), .tbr_lo_n(tbr_lo_n)
    );

    trap_stack #(
        .DEPTH(MAXTL), .ADDR_W(ADDR_W), .IDX_W(TL_W)
    ) u_stack (
        .clk(clk), .rst_n(rst_n),
        .wr_en(trap_ok), .wr_idx(tl_q), .wr_word(save_word),
        .wr_pc(pc_i), .wr_npc(npc_i), .wr_tt(trap_type),
        .rd_idx(rd_idx), .rd_word(rd_word), .rd_pc(rd_pc),
        .rd_npc(rd_npc), .rd_tt(rd_tt)
    );

    // Sequencer state and registered control outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tl_q        <= '0;
            tbr_lo_q    <= '0;
            upd_valid_o <= 1'b0;
            err_o       <= 1'b0;
            pc_o        <= '0;
            npc_o       <= '0;
            ccr_o       <= '0;
            asi_o       <= '0;
            pstate_o    <= '0;
            cwp_o       <= '0;
        end else begin
            upd_valid_o <= trap_ok || ret_ok;
            err_o       <= (trap_req && !trap_ok) || (do_ret && !ret_ok);
            if (trap_ok) begin
                tl_q     <= tl_q + TL_W'(1);
                tbr_lo_q <= tbr_lo_n;
                pc_o     <= vec_pc;
                npc_o    <= vec_pc + ADDR_W'(4);
                ccr_o    <= ccr_i;
                asi_o    <= asi_i;
                pstate_o <= ps_n;
                cwp_o    <= cwp_n;
            end else if (ret_ok) begin
                tl_q     <= tl_q - TL_W'(1);
                pc_o     <= is_done ? rd_npc : rd_pc;
                npc_o    <= is_done ? (rd_npc + ADDR_W'(4)) : rd_npc;
                ccr_o    <= rd_word.ccr;
                asi_o    <= rd_word.asi;
                pstate_o <= rd_word.ps;
                cwp_o    <= rd_word.win[CWP_W-1:0];
            end
        end
    end

    // Level, base and innermost type views
    always_comb begin
        tl_o     = tl_q;
        tbr_o    = {tba_base_i, tbr_lo_q};
        cur_tt_o = (tl_q != '0) ? rd_tt : '0;
    end

    // R7: trap level never exceeds its maximum
    a_r7_tl_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tl_q <= TL_TOP);

    // R7: a legal entry raises the level by one and strobes valid
    a_r7_enter_step: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && tl_q != TL_TOP) |=> (tl_q == $past(tl_q) + TL_W'(1)) && upd_valid_o);

    // R7: entry at the top level is refused without state change
    a_r7_full_error: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && tl_q == TL_TOP) |=> err_o && !upd_valid_o && $stable(tl_q));

    // R6: handler next-PC follows the vector PC
    a_r6_vector_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && tl_q != TL_TOP) |=> (npc_o == pc_o + ADDR_W'(4)) && (pc_o == tbr_o));

    // R3: handler state is privileged with FP and alternate globals
    a_r3_priv_state: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && tl_q != TL_TOP) |=> pstate_o[PS_PRIV] && pstate_o[PS_PEF] && pstate_o[PS_AG]);

    // R8: a legal return lowers the level by one
    a_r8_return_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && (done_req || retry_req) && tl_q != '0) |=> (tl_q == $past(tl_q) - TL_W'(1)));

    // R10: a return at level zero is refused
    a_r10_empty_return: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && (done_req || retry_req) && tl_q == '0) |=> err_o && !upd_valid_o && tl_q == '0);

    // R7: valid and error strobes are exclusive
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_valid_o && err_o));
endmodule

// File: tb/tb_trap_seq_top.sv
module tb_trap_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int MAXTL  = 5;
    localparam int NWIN   = 8;
    localparam int CWP_W  = 3;
    localparam int TL_W   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_req = 0, done_req = 0, retry_req = 0;
    logic [8:0] trap_type = '0;
    logic [7:0] ccr_i = '0, asi_i = '0;
    logic [11:0] pstate_i = '0;
    logic [CWP_W-1:0] cwp_i = '0, cansave_i = '0;
    logic [ADDR_W-1:0] pc_i = '0, npc_i = '0;
    logic [ADDR_W-16:0] tba_base_i = 17'h12345;
    logic upd_valid_o, err_o;
    logic [ADDR_W-1:0] pc_o, npc_o, tbr_o;
    logic [7:0] ccr_o, asi_o;
    logic [11:0] pstate_o;
    logic [CWP_W-1:0] cwp_o;
    logic [TL_W-1:0] tl_o;
    logic [8:0] cur_tt_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_seq_top #(.ADDR_W(ADDR_W), .MAXTL(MAXTL), .NWIN(NWIN)) dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
        .done_req(done_req), .retry_req(retry_req), .ccr_i(ccr_i), .asi_i(asi_i),
        .pstate_i(pstate_i), .cwp_i(cwp_i), .cansave_i(cansave_i), .pc_i(pc_i),
        .npc_i(npc_i), .tba_base_i(tba_base_i), .upd_valid_o(upd_valid_o),
        .err_o(err_o), .pc_o(pc_o), .npc_o(npc_o), .ccr_o(ccr_o), .asi_o(asi_o),
        .pstate_o(pstate_o), .cwp_o(cwp_o), .tl_o(tl_o), .tbr_o(tbr_o),
        .cur_tt_o(cur_tt_o)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    // Behavioural reference state
    int m_tl, m_upd, m_err;
    longint m_pc, m_npc, m_ccr, m_asi, m_ps, m_cwp, m_tbrlo;
    longint s_ccr[MAXTL], s_asi[MAXTL], s_ps[MAXTL], s_cwp[MAXTL];
    longint s_pc[MAXTL], s_npc[MAXTL], s_tt[MAXTL];

    task automatic chk(string tag, string what, longint act, longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        int w;
        longint tba;
        tba = longint'(tba_base_i);
        if (!rst_n) begin
            m_tl = 0; m_upd = 0; m_err = 0; m_tbrlo = 0;
            m_pc = 0; m_npc = 0; m_ccr = 0; m_asi = 0; m_ps = 0; m_cwp = 0;
        end else if (trap_req) begin
            if (m_tl == MAXTL) begin
                m_upd = 0; m_err = 1;
            end else begin
                s_ccr[m_tl] = ccr_i; s_asi[m_tl] = asi_i;
                s_ps[m_tl] = pstate_i & 12'hF3F; s_cwp[m_tl] = cwp_i;
                s_pc[m_tl] = pc_i; s_npc[m_tl] = npc_i; s_tt[m_tl] = trap_type;
                m_tbrlo = (m_tl > 1 ? 16384 : 0) + longint'(trap_type) * 32;
                w = int'(cwp_i);
                if (trap_type == 9'h024) w = w - 1;
                else if (trap_type[8:6] == 3'b010) w = w - int'(cansave_i) - 2;
                else if (trap_type[8:6] == 3'b011) w = w + 1;
                m_cwp = ((w % NWIN) + NWIN) % NWIN;
                m_ps = 12'h015 | ((m_tl >= MAXTL - 1) ? 12'h020 : 12'h000);
                m_tl++;
                m_pc = (tba * 32768 + m_tbrlo) % (64'd1 << 32);
                m_npc = (m_pc + 4) % (64'd1 << 32);
                m_ccr = ccr_i; m_asi = asi_i;
                m_upd = 1; m_err = 0;
            end
        end else if (done_req || retry_req) begin
            if (m_tl == 0) begin
                m_upd = 0; m_err = 1;
            end else begin
                m_tl--;
                if (done_req) begin
                    m_pc = s_npc[m_tl];
                    m_npc = (s_npc[m_tl] + 4) % (64'd1 << 32);
                end else begin
                    m_pc = s_pc[m_tl];
                    m_npc = s_npc[m_tl];
                end
                m_ccr = s_ccr[m_tl]; m_asi = s_asi[m_tl];
                m_ps = s_ps[m_tl]; m_cwp = s_cwp[m_tl];
                m_upd = 1; m_err = 0;
            end
        end else begin
            m_upd = 0; m_err = 0;
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "valid", upd_valid_o, m_upd);
        chk(tag, "err", err_o, m_err);
        chk(tag, "pc", pc_o, m_pc);
        chk(tag, "npc", npc_o, m_npc);
        chk(tag, "ccr", ccr_o, m_ccr);
        chk(tag, "asi", asi_o, m_asi);
        chk(tag, "pstate", pstate_o, m_ps);
        chk(tag, "cwp", cwp_o, m_cwp);
        chk(tag, "tl", tl_o, m_tl);
        chk(tag, "tbr", tbr_o, longint'(tba_base_i) * 32768 + m_tbrlo);
        chk("R12", "cur_tt", cur_tt_o, (m_tl > 0) ? s_tt[m_tl-1] : 0);
    endtask

    // Apply one cycle of stimulus and compare at the following falling edge
    task automatic step(string tag, bit t, bit d, bit r, logic [8:0] tt,
                        logic [7:0] c, logic [7:0] a, logic [11:0] ps,
                        int w, int cs, logic [31:0] p, logic [31:0] np);
        trap_req = t; done_req = d; retry_req = r; trap_type = tt;
        ccr_i = c; asi_i = a; pstate_i = ps; cwp_i = CWP_W'(w);
        cansave_i = CWP_W'(cs); pc_i = p; npc_i = np;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        model_edge();
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        // idle cycle
        step("R1", 0, 0, 0, 9'h000, 8'h00, 8'h00, 12'h000, 0, 0, 32'h0, 32'h0);
        // generic trap from level 0
        step("R6", 1, 0, 0, 9'h041, 8'hA5, 8'h80, 12'hFFF, 3, 1, 32'h0000_1000, 32'h0000_1004);
        // clean-window trap from window 0 wraps to 7
        step("R4", 1, 0, 0, 9'h024, 8'h11, 8'h22, 12'h0C4, 0, 2, 32'h0000_2000, 32'h0000_2008);
        // spill trap from level 2 sets the nested bit, 1-3-2 wraps to 4
        step("R5", 1, 0, 0, 9'h085, 8'h33, 8'h44, 12'h315, 1, 3, 32'h0000_3000, 32'h0000_3004);
        // fill trap from window 7 wraps to 0
        step("R4", 1, 0, 0, 9'h0C2, 8'h55, 8'h66, 12'h800, 7, 0, 32'h0000_4000, 32'h0000_4004);
        // entry at MAXTL-1 sets red state
        step("R3", 1, 0, 0, 9'h1FF, 8'h77, 8'h88, 12'hA5A, 5, 6, 32'hFFFF_FFF8, 32'hFFFF_FFFC);
        // entry at MAXTL is refused
        step("R7", 1, 0, 0, 9'h033, 8'h99, 8'hAA, 12'h123, 2, 1, 32'h0000_5000, 32'h0000_5004);
        // done and retry together: done wins, resumes after saved next-PC wrap
        step("R11", 0, 1, 1, 9'h000, 8'h00, 8'h00, 12'h000, 0, 0, 32'h0, 32'h0);
        // retry restores saved PC pair and context
        step("R9", 0, 0, 1, 9'h000, 8'h00, 8'h00, 12'h000, 0, 0, 32'h0, 32'h0);
        // trap and done together: trap wins
        step("R11", 1, 1, 0, 9'h0A0, 8'hC3, 8'h3C, 12'h0F0, 6, 2, 32'h0000_6000, 32'h0000_6010);
        // unwind the stack in order
        step("R8", 0, 1, 0, 9'h000, 8'h00, 8'h00, 12'h000, 0, 0, 32'h0, 32'h0);
        step("R13", 0, 0, 1, 9'h000, 8'h00, 8'h00, 12'h000, 0, 0, 32'h0, 32'h0);
        step("R13", 0, 1, 0, 9'h000, 8'h00, 8'h00, 12'h000, 0, 0, 32'h0, 32'h0);
        step("R2", 0, 0, 1, 9'h000, 8'h00, 8'h00, 12'h000, 0, 0, 32'h0, 32'h0);
        // return at level zero is refused
        step("R10", 0, 1, 0, 9'h000, 8'h00, 8'h00, 12'h000, 0, 0, 32'h0, 32'h0);
        step("R10", 0, 0, 1, 9'h000, 8'h00, 8'h00, 12'h000, 0, 0, 32'h0, 32'h0);
        // re-enter after empty and retry once more
        step("R6", 1, 0, 0, 9'h100, 8'h5A, 8'hF0, 12'hFFF, 4, 0, 32'h0000_7000, 32'h0000_7004);
        step("R2", 0, 0, 1, 9'h000, 8'h00, 8'h00, 12'h000, 0, 0, 32'h0, 32'h0);
        step("R1", 0, 0, 0, 9'h000, 8'h00, 8'h00, 12'h000, 0, 0, 32'h0, 32'h0);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule